// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block joins an A bus and a B bus with two independent data lanes, one per direction, each 18 bits wide by default. Every lane has its own storage word and three controls: a latch enable, a capture clock and a drive enable. With the latch enable high the lane passes its input straight to its output. With the latch enable low, the lane either loads a fresh word on a rising capture-clock edge or holds what it stored. The block is therefore usable as a pass-through, a pipeline register or a parking register in either direction.

All logic runs on one fast system clock. The capture clocks arrive as ordinary signals: they are synchronised and edge-detected, so a register load lands a few system cycles after the capture edge, while the transparent path is purely combinational. Each port leaves the block as a data word plus one drive-enable bit for the pad ring. The A-to-B drive enable is active high and the B-to-A drive enable is active low.

Top module: `ubt_xcvr`

## Requirements
- R1: Both lanes carry WIDTH bits (default 18), and each bit of the input reaches the same bit position of the opposite port's output.
- R2: While a lane's latch enable is high, its output data equals its input data in the same cycle.
- R3: While the latch enable is low, a low-to-high change of the lane's capture clock stores the input word. The stored word appears at the output no later than the fourth system-clock edge after the change, and not before the second. The input must stay stable over that window.
- R4: While the latch enable is low and the capture clock stays steady, the output keeps its stored value whatever the input does.
- R5: When the latch enable falls with the capture clock steady, the output keeps the last value that passed through transparently.
- R6: b_drive equals ab_oe (1 = B port driven, 0 = high impedance).
- R7: a_drive equals the inverse of ba_oe_n (0 on ba_oe_n = A port driven, 1 = high impedance).
- R8: A synchronous active-high reset clears both storage words to zero, and it leaves the drive enables following their controls.
- R9: A high-to-low change of a capture clock loads nothing.
- R10: The controls and data of one lane have no effect on the other lane's output.
- R11: The output data word shows the lane's transparent or stored value even while that port's drive enable is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | WIDTH | Word received from the A bus |
| b_in | input | WIDTH | Word received from the B bus |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B latch enable |
| ab_clk | input | 1 | A-to-B capture clock |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A latch enable |
| ba_clk | input | 1 | B-to-A capture clock |
| b_out | output | WIDTH | Word to drive onto the B bus |
| b_drive | output | 1 | B pad drive enable |
| a_out | output | WIDTH | Word to drive onto the A bus |
| a_drive | output | 1 | A pad drive enable |

## Verification
The lanes are tried with transparent traffic, a rising capture edge, a falling capture edge, and input churn while holding. Only the correct mode matches all four outcomes: transparency must track every new word, the rising edge must change the output only after the synchroniser delay, and the falling edge and the churn must leave it untouched. Alternating bit patterns such as 0x2A5A5 and 0x15A5A expose swapped or stuck bits. Every expectation also records the other lane's output and both drive enables, so crosstalk between lanes and wrong enable polarity show up on any step.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    localparam int unsigned BUS_W = 18;

    // What a lane's storage word does on the next system-clock edge
    typedef enum logic [1:0] {
        LANE_TRACK = 2'd0,   // latch open: storage follows input
        LANE_LOAD  = 2'd1,   // capture edge seen: take input once
        LANE_KEEP  = 2'd2    // hold stored word
    } lane_mode_e;

    function automatic lane_mode_e lane_mode(input logic latch_en, input logic load);
        if (latch_en)  return LANE_TRACK;
        else if (load) return LANE_LOAD;
        else           return LANE_KEEP;
    endfunction

    function automatic logic drive_from_oe(input logic oe, input logic active_low);
        return active_low ? ~oe : oe;
    endfunction

endpackage

// File: rtl/ubt_edge_sync.sv
module ubt_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_pulse
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_q;
    logic               rise_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            rise_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[CHAIN_W-2:0], async_in};
            rise_q  <= chain_q[STAGES-1] & ~chain_q[STAGES];
        end
    end

    assign rise_pulse = rise_q;

    // R3: a detected edge lasts exactly one cycle
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/ubt_lane.sv
module ubt_lane
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH      = BUS_W,
    parameter bit          OE_ACT_LOW = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             latch_en,
    input  logic             load,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             drive
);
    logic [WIDTH-1:0] store_q;
    lane_mode_e       mode;

    assign mode = lane_mode(latch_en, load);

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                LANE_TRACK, LANE_LOAD: store_q <= din;
                default:               store_q <= store_q;
            endcase
        end
    end

    assign dout  = latch_en ? din : store_q;
    assign drive = drive_from_oe(oe, OE_ACT_LOW);

    // R4: closed latch with no load keeps the output steady
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !load) ##1 !latch_en |-> $stable(dout));

    // R5: on latch close the last transparent word stays
    a_r5_close_keeps: assert property (@(posedge clk) disable iff (rst)
        ($fell(latch_en) && !$past(rst)) |-> dout == $past(din));

    // R3: a load with the latch closed shows the loaded word
    a_r3_load_word: assert property (@(posedge clk) disable iff (rst)
        (load && !latch_en) |=> (latch_en || dout == $past(din)));

    // R8: reset leaves a cleared word on a closed lane
    a_r8_reset_clear: assert property (@(posedge clk)
        rst |=> (latch_en || dout == '0));

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr
    import ubt_pkg::*;
#(
    parameter int unsigned WIDTH       = BUS_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             ab_oe,
    input  logic             ab_le,
    input  logic             ab_clk,
    input  logic             ba_oe_n,
    input  logic             ba_le,
    input  logic             ba_clk,
    output logic [WIDTH-1:0] b_out,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_out,
    output logic             a_drive
);
    logic ab_load;
    logic ba_load;

    ubt_edge_sync #(.STAGES(SYNC_STAGES)) u_ab_sync (
        .clk(clk), .rst(rst), .async_in(ab_clk), .rise_pulse(ab_load)
    );

    ubt_edge_sync #(.STAGES(SYNC_STAGES)) u_ba_sync (
        .clk(clk), .rst(rst), .async_in(ba_clk), .rise_pulse(ba_load)
    );

    ubt_lane #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b0)) u_ab_lane (
        .clk(clk), .rst(rst), .din(a_in), .latch_en(ab_le), .load(ab_load),
        .oe(ab_oe), .dout(b_out), .drive(b_drive)
    );

    ubt_lane #(.WIDTH(WIDTH), .OE_ACT_LOW(1'b1)) u_ba_lane (
        .clk(clk), .rst(rst), .din(b_in), .latch_en(ba_le), .load(ba_load),
        .oe(ba_oe_n), .dout(a_out), .drive(a_drive)
    );

    // R10: a B-to-A capture edge never disturbs a closed A-to-B lane
    a_r10_lane_isolation: assert property (@(posedge clk) disable iff (rst)
        (!ab_le && !ab_load && ba_load) ##1 !ab_le |-> $stable(b_out));

endmodule

// File: tb/ubt_xcvr_tb_top.sv
module ubt_xcvr_tb_top;
    localparam int W = 18;

    typedef struct {
        string      tag;
        logic [W-1:0] a_out;
        logic [W-1:0] b_out;
        logic       a_drv;
        logic       b_drv;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic ab_oe = 1'b0, ab_le = 1'b0, ab_clk = 1'b0;
    logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0;
    logic [W-1:0] a_out, b_out;
    logic a_drive, b_drive;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    exp_t sb_q[$];

    logic [W-1:0] mdl_a, mdl_b;

    always #5 clk = ~clk;

    ubt_xcvr #(.WIDTH(W)) dut_i (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .ab_oe(ab_oe), .ab_le(ab_le), .ab_clk(ab_clk),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk),
        .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // driver side: push the model's expectation for the coming negedge
    task automatic expect_now(input string tag);
        exp_t e;
        e.tag   = tag;
        e.a_out = mdl_a;
        e.b_out = mdl_b;
        e.a_drv = ~ba_oe_n;
        e.b_drv = ab_oe;
        sb_q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    // monitor side
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (a_out !== e.a_out || b_out !== e.b_out ||
                a_drive !== e.a_drv || b_drive !== e.b_drv) begin
                errors++;
                $display("FAIL %s: actual a=%h b=%h ad=%b bd=%b expected a=%h b=%h ad=%b bd=%b",
                    e.tag, a_out, b_out, a_drive, b_drive,
                    e.a_out, e.b_out, e.a_drv, e.b_drv);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        mdl_a = '0;
        mdl_b = '0;
        step(3);
        expect_now("R8 reset clears both words");
        ab_oe = 1'b1; ba_oe_n = 1'b0;
        expect_now("R8 R6 R7 enables follow controls in reset");
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        step(1);
        rst = 1'b0;
        step(1);

        // R2 transparent, both directions, R1 bit patterns
        ab_le = 1'b1; a_in = 18'h2A5A5; mdl_b = a_in;
        expect_now("R2 R1 A-to-B transparent 2A5A5");
        a_in = 18'h15A5A; mdl_b = a_in;
        expect_now("R2 R1 A-to-B transparent 15A5A");
        ba_le = 1'b1; b_in = 18'h3C3C3; mdl_a = b_in;
        expect_now("R2 B-to-A transparent");
        step(1);

        // R5 close latch keeps last transparent word
        ab_le = 1'b0; ba_le = 1'b0;
        step(1);
        a_in = 18'h00FFF; b_in = 18'h1E1E1;
        expect_now("R5 latch close keeps last word");

        // R4 hold under input churn, capture clock low
        for (int i = 0; i < 3; i++) begin
            a_in = 18'h3FFFF ^ (i * 18'h01111);
            step(1);
            expect_now("R4 hold with churn");
        end

        // R3 rising capture edge, timing window
        a_in = 18'h12345;
        ab_clk = 1'b1;
        step(1);
        expect_now("R3 not yet loaded after 1 edge");
        step(1);
        expect_now("R3 not yet loaded after 2 edges");
        step(2);
        mdl_b = 18'h12345;
        expect_now("R3 loaded by 4th edge");

        // R4 hold with capture clock steady high
        a_in = 18'h0AAAA;
        step(3);
        expect_now("R4 hold with clock high");

        // R9 falling edge loads nothing
        a_in = 18'h0F0F0;
        ab_clk = 1'b0;
        step(5);
        expect_now("R9 falling edge no load");

        // R6 R7 R11 enables off/on while data visible
        ab_oe = 1'b1;
        expect_now("R6 B drive on");
        ba_oe_n = 1'b0;
        expect_now("R7 A drive on");
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        expect_now("R11 data visible with drives off");

        // B-to-A register load, R10 A-to-B untouched
        b_in = 18'h2BEEF;
        ba_clk = 1'b1;
        step(4);
        mdl_a = 18'h2BEEF;
        expect_now("R3 R10 B-to-A load, A-to-B unchanged");
        ab_le = 1'b1; a_in = 18'h33333; mdl_b = a_in;
        expect_now("R10 A-to-B open does not touch B-to-A");
        ab_le = 1'b0;
        step(1);

        // R8 reset mid-run
        rst = 1'b1;
        ab_oe = 1'b1;
        step(1);
        mdl_a = '0; mdl_b = '0;
        expect_now("R8 reset mid-run clears, enable kept");
        rst = 1'b0;
        step(2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule